// File: doc/BRIEF.md
# Graphics Memory Port Decoder

This block sits behind a byte-wide, auto-addressed graphics memory window. Every access to the window carries a small word address. Its upper bits name a port, and one low bit chooses between the shared address pointer and the data path. Pointer accesses load the 16-bit pointer or read it back one byte at a time. A data access is routed to one of six memory regions: two flash banks, device-service storage, cartridge ROM storage, graphics RAM and plain RAM. The block reports the chosen region, the port index within that region, and a flat memory address made from that index above the pointer. The pointer then advances.

Data accesses also update a module bank number, which a separate cartridge-window mapper uses to select its backing store. The bank numbering differs from the port numbering for the graphics RAM ports. Some port classes leave the bank alone. A card-disable input hides every region except the low system area below a pointer threshold. The memories themselves are outside this block. Results appear one clock after the request.

Top module: `gfx_port_decoder`

## Requirements
- R1: The port number is address bits [9:2] (`acc_addr[9:2]`). Address bit 1 set makes the access a pointer access and produces no data result. Bit 1 clear makes it a data access.
- R2: A data access to ports 0–7 gives region code 1 (flash A) with index = port. The flat address is {index[2:0], pointer[15:0]}, using the pointer value before the access.
- R3: Ports 8–15 give region code 2 (flash B) with index = port − 8.
- R4: Ports 16–23 give region code 3 (device-service storage) with index = port − 16. Ports 24–31 give region code 4 (cartridge ROM storage) with index = port − 24.
- R5: Ports 32–33 give region code 5 (graphics RAM) with index = port − 32. Ports 48–49 give region code 6 (RAM) with index = port − 48. Any other port gives region code 0 with index 0 and flat address 0.
- R6: When `gram_en` is 1, ports 0 and 1 go to region code 5 with index = port, and the module bank becomes port + 16.
- R7: A served data access sets the module bank to the port for ports 0–15 and to port − 16 for ports 32–33. Ports 16–31, ports 48–49, unused ports and unserved accesses leave the bank unchanged.
- R8: With `card_en` at 0, a data access is served only while the pointer is below 0x6000. Otherwise the result carries region code 0 and the bank is unchanged.
- R9: After reset the module bank is 0, the pointer is 0, the last port is 0, and no result or pointer read data is flagged valid.
- R10: Pointer writes load the high byte first and the low byte second. Pointer reads return the high byte first and the low byte second, one cycle after the request. Any data access restarts both byte sequences at the high byte.
- R11: Every data access, served or not, increments the pointer by one, wrapping from 0xFFFF to 0x0000.
- R12: `out_new_port` is 1 with a result exactly when that data access used a different port than the previous data access.
- R13: A data access sampled at one rising edge shows its result, with `out_valid` = 1 and `out_we` equal to the request's write flag, right after that edge. The module bank updates at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 9 | Word address bits [9:1] |
| acc_wdata | input | 8 | Write byte (used by pointer loads) |
| card_en | input | 1 | Card enable; 0 restricts service to the low area |
| gram_en | input | 1 | Sends ports 0–1 to graphics RAM |
| out_valid | output | 1 | Data-access result valid |
| out_region | output | 3 | Region code |
| out_port_idx | output | 3 | Port index within the region |
| out_flat_addr | output | 19 | {index, pointer} memory address |
| out_we | output | 1 | Write flag of the routed access |
| out_new_port | output | 1 | Port differs from the previous data access |
| module_bank | output | 6 | Last selected module bank |
| ptr_value | output | 16 | Current pointer |
| ptr_rvalid | output | 1 | Pointer read byte valid |
| ptr_rdata | output | 8 | Pointer read byte |

## Verification
The hardest case to reach is the card-disable boundary. An access must be served at pointer 0x5FFF and refused at 0x6000, and only the auto-increment of the first access brings the pointer across. The bench loads 0x5FFF, issues two data accesses in a row on different ports, and checks that the second returns region 0, leaves the bank as the first access set it, and still pulses the new-port flag. A second hard case is a half-written pointer: one byte is written, then a data access interrupts, and the next pointer write must land in the high byte again.

// File: rtl/gpd_pkg.sv
`timescale 1ns/1ps
package gpd_pkg;

   // Region codes seen at the block's output
   typedef enum logic [2:0] {
      RGN_NONE    = 3'd0,
      RGN_FLASH_A = 3'd1,
      RGN_FLASH_B = 3'd2,
      RGN_DSR     = 3'd3,
      RGN_CROM    = 3'd4,
      RGN_GRAM    = 3'd5,
      RGN_RAM     = 3'd6
   } region_e;

endpackage

// File: rtl/gpd_route.sv
`timescale 1ns/1ps
// Combinational port classifier: region, index and bank update.
module gpd_route
   import gpd_pkg::*;
#(
   parameter int PORT_W         = 8,
   parameter int IDX_W          = 3,
   parameter int BANK_W         = 6,
   parameter int B_BASE         = 8,
   parameter int DSR_BASE       = 16,
   parameter int CROM_BASE      = 24,
   parameter int GRAM_BASE      = 32,
   parameter int RAM_BASE       = 48,
   parameter int DUAL_SPAN      = 2,
   parameter int GRAM_BANK_BASE = 16,
   parameter bit LOW_GRAM_ALIAS = 1'b1
) (
   input  logic [PORT_W-1:0] port,
   input  logic              gram_en,
   output region_e           region,
   output logic [IDX_W-1:0]  idx,
   output logic              bank_upd,
   output logic [BANK_W-1:0] bank_val
);

   localparam logic [PORT_W-1:0] P_B     = PORT_W'(B_BASE);
   localparam logic [PORT_W-1:0] P_DSR   = PORT_W'(DSR_BASE);
   localparam logic [PORT_W-1:0] P_CROM  = PORT_W'(CROM_BASE);
   localparam logic [PORT_W-1:0] P_GRAM  = PORT_W'(GRAM_BASE);
   localparam logic [PORT_W-1:0] P_GEND  = PORT_W'(GRAM_BASE + DUAL_SPAN);
   localparam logic [PORT_W-1:0] P_RAM   = PORT_W'(RAM_BASE);
   localparam logic [PORT_W-1:0] P_REND  = PORT_W'(RAM_BASE + DUAL_SPAN);
   localparam logic [PORT_W-1:0] P_ALIAS = PORT_W'(DUAL_SPAN);
   localparam logic [PORT_W-1:0] P_GSHIFT = PORT_W'(GRAM_BASE - GRAM_BANK_BASE);

   logic alias_hit;

   generate
      if (LOW_GRAM_ALIAS) begin : g_alias
         assign alias_hit = gram_en && (port < P_ALIAS);
      end else begin : g_no_alias
         logic unused_gram_en;
         assign unused_gram_en = gram_en;
         assign alias_hit      = 1'b0;
      end
   endgenerate

   always_comb begin
      region   = RGN_NONE;
      idx      = '0;
      bank_upd = 1'b0;
      bank_val = '0;
      if (alias_hit) begin
         region   = RGN_GRAM;
         idx      = IDX_W'(port);
         bank_upd = 1'b1;
         bank_val = BANK_W'(port) + BANK_W'(GRAM_BANK_BASE);
      end else if (port < P_B) begin
         region   = RGN_FLASH_A;
         idx      = IDX_W'(port);
         bank_upd = 1'b1;
         bank_val = BANK_W'(port);
      end else if (port < P_DSR) begin
         region   = RGN_FLASH_B;
         idx      = IDX_W'(port - P_B);
         bank_upd = 1'b1;
         bank_val = BANK_W'(port);
      end else if (port < P_CROM) begin
         region = RGN_DSR;
         idx    = IDX_W'(port - P_DSR);
      end else if (port < P_GRAM) begin
         region = RGN_CROM;
         idx    = IDX_W'(port - P_CROM);
      end else if (port < P_GEND) begin
         region   = RGN_GRAM;
         idx      = IDX_W'(port - P_GRAM);
         bank_upd = 1'b1;
         bank_val = BANK_W'(port - P_GSHIFT);
      end else if ((port >= P_RAM) && (port < P_REND)) begin
         region = RGN_RAM;
         idx    = IDX_W'(port - P_RAM);
      end
   end

endmodule

// File: rtl/gpd_ptr.sv
`timescale 1ns/1ps
// Auto-incrementing pointer with byte-serial load and readback.
module gpd_ptr #(
   parameter int BYTE_W = 8,
   parameter int PTR_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ptr_wr,
   input  logic              ptr_rd,
   input  logic              data_acc,
   input  logic [BYTE_W-1:0] wdata,
   output logic [PTR_W-1:0]  ptr_q,
   output logic              rvalid,
   output logic [BYTE_W-1:0] rdata
);

   logic wr_lo_q;
   logic rd_lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         wr_lo_q <= 1'b0;
         rd_lo_q <= 1'b0;
         rvalid  <= 1'b0;
         rdata   <= '0;
      end else begin
         rvalid <= ptr_rd;
         if (data_acc) begin
            ptr_q   <= ptr_q + PTR_W'(1);
            wr_lo_q <= 1'b0;
            rd_lo_q <= 1'b0;
         end else begin
            if (ptr_wr) begin
               if (wr_lo_q) ptr_q[BYTE_W-1:0]     <= wdata;
               else         ptr_q[PTR_W-1:BYTE_W] <= wdata;
               wr_lo_q <= !wr_lo_q;
            end
            if (ptr_rd) begin
               rdata   <= rd_lo_q ? ptr_q[BYTE_W-1:0] : ptr_q[PTR_W-1:BYTE_W];
               rd_lo_q <= !rd_lo_q;
            end
         end
      end
   end

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      data_acc |=> (ptr_q == $past(ptr_q) + PTR_W'(1))) else $error("pointer step"); // R11
   AST_PTR_LOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_wr && !data_acc && wr_lo_q) |=> (ptr_q[BYTE_W-1:0] == $past(wdata))) else $error("low byte load"); // R10
   AST_PTR_HIGH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_wr && !data_acc && !wr_lo_q) |=> (ptr_q[PTR_W-1:BYTE_W] == $past(wdata))) else $error("high byte load"); // R10

endmodule

// File: rtl/gpd_bank.sv
`timescale 1ns/1ps
// Module bank register and port-change tracking.
module gpd_bank #(
   parameter int PORT_W   = 8,
   parameter int BANK_W   = 6,
   parameter int BANK_TOP = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dacc,
   input  logic              serve,
   input  logic [PORT_W-1:0] port,
   input  logic              bank_upd,
   input  logic [BANK_W-1:0] bank_val,
   output logic [BANK_W-1:0] bank_q,
   output logic              new_port
);

   logic [PORT_W-1:0] last_port_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q      <= '0;
         last_port_q <= '0;
         new_port    <= 1'b0;
      end else begin
         new_port <= dacc && (port != last_port_q);
         if (dacc) last_port_q <= port;
         if (dacc && serve && bank_upd) bank_q <= bank_val;
      end
   end

   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (dacc && !(serve && bank_upd)) |=> (bank_q == $past(bank_q))) else $error("bank moved"); // R7
   AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (dacc && serve && bank_upd) |=> (bank_q == $past(bank_val))) else $error("bank not loaded"); // R7
   AST_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      bank_q < BANK_W'(BANK_TOP)) else $error("bank out of range"); // R7
   AST_NEW_PORT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      !dacc |=> !new_port) else $error("spurious new-port"); // R12

endmodule

// File: rtl/gfx_port_decoder.sv
`timescale 1ns/1ps
// Graphics memory window port decoder, top level.
module gfx_port_decoder
   import gpd_pkg::*;
#(
   parameter int ADDR_W         = 10,
   parameter int BYTE_W         = 8,
   parameter int IDX_W          = 3,
   parameter int BANK_W         = 6,
   parameter int B_BASE         = 8,
   parameter int DSR_BASE       = 16,
   parameter int CROM_BASE      = 24,
   parameter int GRAM_BASE      = 32,
   parameter int RAM_BASE       = 48,
   parameter int DUAL_SPAN      = 2,
   parameter int GRAM_BANK_BASE = 16,
   parameter bit LOW_GRAM_ALIAS = 1'b1,
   parameter int LOW_LIMIT      = 'h6000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    acc_valid,
   input  logic                    acc_write,
   input  logic [ADDR_W-1:1]       acc_addr,
   input  logic [BYTE_W-1:0]       acc_wdata,
   input  logic                    card_en,
   input  logic                    gram_en,
   output logic                    out_valid,
   output logic [2:0]              out_region,
   output logic [IDX_W-1:0]        out_port_idx,
   output logic [IDX_W+2*BYTE_W-1:0] out_flat_addr,
   output logic                    out_we,
   output logic                    out_new_port,
   output logic [BANK_W-1:0]       module_bank,
   output logic [2*BYTE_W-1:0]     ptr_value,
   output logic                    ptr_rvalid,
   output logic [BYTE_W-1:0]       ptr_rdata
);

   localparam int PTR_W    = 2 * BYTE_W;
   localparam int PORT_LSB = 2;
   localparam int PORT_W   = ADDR_W - PORT_LSB;
   localparam int FLAT_W   = IDX_W + PTR_W;
   localparam int SLOT     = B_BASE;
   localparam int BANK_TOP = GRAM_BANK_BASE + DUAL_SPAN;
   localparam logic [PTR_W-1:0] LIMIT = PTR_W'(LOW_LIMIT);

   initial begin
      assert ((1 << IDX_W) >= SLOT) else $error("index too narrow for a region");
      assert ((1 << BANK_W) >= BANK_TOP) else $error("bank too narrow");
      assert ((1 << PORT_W) >= RAM_BASE + DUAL_SPAN) else $error("port field too narrow");
      assert (DSR_BASE - B_BASE == SLOT && CROM_BASE - DSR_BASE == SLOT) else $error("uneven slots");
   end

   logic [PORT_W-1:0] port;
   logic              sel_ptr;
   logic              dacc;
   logic              ptr_wr;
   logic              ptr_rd;
   logic              serve;
   region_e           rt_region;
   logic [IDX_W-1:0]  rt_idx;
   logic              rt_bank_upd;
   logic [BANK_W-1:0] rt_bank_val;
   logic [PTR_W-1:0]  ptr_q;

   assign port    = acc_addr[ADDR_W-1:PORT_LSB];
   assign sel_ptr = acc_addr[1];
   assign dacc    = acc_valid && !sel_ptr;
   assign ptr_wr  = acc_valid && sel_ptr && acc_write;
   assign ptr_rd  = acc_valid && sel_ptr && !acc_write;
   assign serve   = card_en || (ptr_q < LIMIT);

   gpd_route #(
      .PORT_W(PORT_W), .IDX_W(IDX_W), .BANK_W(BANK_W),
      .B_BASE(B_BASE), .DSR_BASE(DSR_BASE), .CROM_BASE(CROM_BASE),
      .GRAM_BASE(GRAM_BASE), .RAM_BASE(RAM_BASE), .DUAL_SPAN(DUAL_SPAN),
      .GRAM_BANK_BASE(GRAM_BANK_BASE), .LOW_GRAM_ALIAS(LOW_GRAM_ALIAS)
   ) route_i (
      .port(port), .gram_en(gram_en), .region(rt_region), .idx(rt_idx),
      .bank_upd(rt_bank_upd), .bank_val(rt_bank_val)
   );

   gpd_ptr #(.BYTE_W(BYTE_W), .PTR_W(PTR_W)) ptr_i (
      .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_rd(ptr_rd),
      .data_acc(dacc), .wdata(acc_wdata), .ptr_q(ptr_q),
      .rvalid(ptr_rvalid), .rdata(ptr_rdata)
   );

   gpd_bank #(.PORT_W(PORT_W), .BANK_W(BANK_W), .BANK_TOP(BANK_TOP)) bank_i (
      .clk(clk), .rst_n(rst_n), .dacc(dacc), .serve(serve), .port(port),
      .bank_upd(rt_bank_upd), .bank_val(rt_bank_val),
      .bank_q(module_bank), .new_port(out_new_port)
   );

   region_e          region_q;
   logic [IDX_W-1:0] idx_q;
   logic [FLAT_W-1:0] flat_q;
   logic             hit;

   assign hit = serve && (rt_region != RGN_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_we    <= 1'b0;
         region_q  <= RGN_NONE;
         idx_q     <= '0;
         flat_q    <= '0;
      end else begin
         out_valid <= dacc;
         if (dacc) begin
            out_we   <= acc_write;
            region_q <= hit ? rt_region : RGN_NONE;
            idx_q    <= hit ? rt_idx : '0;
            flat_q   <= hit ? {rt_idx, ptr_q} : '0;
         end
      end
   end

   assign out_region    = region_q;
   assign out_port_idx  = idx_q;
   assign out_flat_addr = flat_q;
   assign ptr_value     = ptr_q;

   AST_CARD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (dacc && !card_en && (ptr_q >= LIMIT)) |=> (region_q == RGN_NONE)) else $error("card gate"); // R8
   AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      dacc |=> (out_valid && (out_we == $past(acc_write)))) else $error("result latency"); // R13
   AST_PTR_ACCESS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && sel_ptr) |=> !out_valid) else $error("pointer access gave data result"); // R1
   AST_FLAT_POINTER: assert property (@(posedge clk) disable iff (!rst_n)
      (dacc && hit) |=> (flat_q[PTR_W-1:0] == $past(ptr_q))) else $error("flat address low part"); // R2
   AST_LOW_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
      (LOW_GRAM_ALIAS && dacc && serve && gram_en && (port < PORT_W'(DUAL_SPAN))) |=> (region_q == RGN_GRAM)) else $error("low alias"); // R6

endmodule

// File: tb/gfx_port_decoder_tb_top.sv
`timescale 1ns/1ps
module gfx_port_decoder_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [9:1]  acc_addr = '0;
   logic [7:0]  acc_wdata = '0;
   logic        card_en = 1'b1;
   logic        gram_en = 1'b0;
   logic        out_valid;
   logic [2:0]  out_region;
   logic [2:0]  out_port_idx;
   logic [18:0] out_flat_addr;
   logic        out_we;
   logic        out_new_port;
   logic [5:0]  module_bank;
   logic [15:0] ptr_value;
   logic        ptr_rvalid;
   logic [7:0]  ptr_rdata;

   always #2.5 clk = ~clk;

   gfx_port_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .card_en(card_en), .gram_en(gram_en),
      .out_valid(out_valid), .out_region(out_region), .out_port_idx(out_port_idx),
      .out_flat_addr(out_flat_addr), .out_we(out_we), .out_new_port(out_new_port),
      .module_bank(module_bank), .ptr_value(ptr_value), .ptr_rvalid(ptr_rvalid),
      .ptr_rdata(ptr_rdata)
   );

   typedef struct {
      logic [2:0]  rg;
      logic [2:0]  ix;
      logic [18:0] fa;
      logic        we;
      logic        np;
      logic [5:0]  bk;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_tests = 0;
   int   n_fail  = 0;
   bit   done    = 1'b0;

   // reference state
   logic [15:0] ptr_m = '0;
   logic [5:0]  bank_m = '0;
   int          last_m = 0;
   bit          wlo_m = 1'b0;
   bit          rlo_m = 1'b0;

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic void model_route(input int p, input bit ge, output int rg, output int ix,
                                       output bit up, output int bv);
      rg = 0; ix = 0; up = 1'b0; bv = 0;
      if (ge && p < 2)              begin rg = 5; ix = p;      up = 1'b1; bv = p + 16; end
      else if (p < 8)               begin rg = 1; ix = p;      up = 1'b1; bv = p;      end
      else if (p < 16)              begin rg = 2; ix = p - 8;  up = 1'b1; bv = p;      end
      else if (p < 24)              begin rg = 3; ix = p - 16; end
      else if (p < 32)              begin rg = 4; ix = p - 24; end
      else if (p == 32 || p == 33)  begin rg = 5; ix = p - 32; up = 1'b1; bv = p - 16; end
      else if (p == 48 || p == 49)  begin rg = 6; ix = p - 48; end
   endfunction

   // driver: compute expected result, push it, issue the access
   task automatic data_acc(input int port, input bit we);
      int rg, ix, bv; bit up, served; exp_t e;
      model_route(port, gram_en, rg, ix, up, bv);
      served = card_en || (ptr_m < 16'h6000);
      if (!served) begin rg = 0; ix = 0; up = 1'b0; end
      e.rg  = 3'(rg);
      e.ix  = 3'(ix);
      e.fa  = (rg != 0) ? {3'(ix), ptr_m} : 19'd0;
      e.we  = we;
      e.np  = (port != last_m);
      if (up) bank_m = 6'(bv);
      e.bk  = bank_m;
      e.tag = !served ? "R8" : (gram_en && port < 2) ? "R6" :
              (rg == 1) ? "R2" : (rg == 2) ? "R3" : (rg == 3 || rg == 4) ? "R4" : "R5";
      last_m = port;
      ptr_m  = ptr_m + 16'd1;
      wlo_m  = 1'b0;
      rlo_m  = 1'b0;
      exp_q.push_back(e);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = we; acc_addr = {8'(port), 1'b0};
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic ptr_wbyte(input int port, input logic [7:0] b);
      if (wlo_m) ptr_m[7:0] = b; else ptr_m[15:8] = b;
      wlo_m = !wlo_m;
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b1; acc_addr = {8'(port), 1'b1}; acc_wdata = b;
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic set_ptr(input int port, input logic [15:0] v);
      ptr_wbyte(port, v[15:8]);
      ptr_wbyte(port, v[7:0]);
      chk("R10", "pointer load", ptr_value, ptr_m);
   endtask

   task automatic ptr_rbyte(input int port);
      logic [7:0] e;
      e = rlo_m ? ptr_m[7:0] : ptr_m[15:8];
      rlo_m = !rlo_m;
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b0; acc_addr = {8'(port), 1'b1};
      @(negedge clk);
      acc_valid = 1'b0;
      chk("R10", "pointer read valid", ptr_rvalid, 1);
      chk("R10", "pointer read byte", ptr_rdata, e);
   endtask

   // monitor: pop and compare each result as it appears
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            chk("R1", "unexpected data result", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.tag, "region", out_region, e.rg);
            chk(e.tag, "port index", out_port_idx, e.ix);
            chk(e.tag, "flat address", out_flat_addr, e.fa);
            chk("R7", "module bank", module_bank, e.bk);
            chk("R12", "new port", out_new_port, e.np);
            chk("R13", "write flag", out_we, e.we);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      chk("R9", "bank in reset", module_bank, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", "pointer after reset", ptr_value, 0);
      chk("R9", "bank after reset", module_bank, 0);
      chk("R9", "no result after reset", out_valid, 0);
      chk("R9", "no pointer data after reset", ptr_rvalid, 0);

      // R1: pointer access through a nonzero port field hits the pointer only
      set_ptr(20, 16'h1234);
      ptr_rbyte(7);
      ptr_rbyte(7);

      // R2 / R12: port 0 equals reset last port -> no new-port pulse
      data_acc(0, 1'b0);
      data_acc(5, 1'b1);
      data_acc(12, 1'b0);                 // R3
      data_acc(18, 1'b0);                 // R4 device storage, bank held
      data_acc(30, 1'b1);                 // R4 cartridge ROM
      data_acc(33, 1'b0);                 // R5 graphics RAM, bank 17
      data_acc(49, 1'b1);                 // R5 RAM
      data_acc(40, 1'b0);                 // R5 unused port
      data_acc(40, 1'b0);                 // R12 repeat, no pulse
      chk("R11", "pointer after data accesses", ptr_value, ptr_m);

      // R6: low ports aliased to graphics RAM
      gram_en = 1'b1;
      data_acc(1, 1'b0);
      data_acc(0, 1'b1);
      gram_en = 1'b0;
      data_acc(0, 1'b0);

      // R10: data access restarts the pointer byte sequence
      ptr_wbyte(3, 8'h77);
      data_acc(2, 1'b0);
      ptr_wbyte(3, 8'h55);
      @(negedge clk);
      chk("R10", "high byte after restart", ptr_value[15:8], 8'h55);
      ptr_wbyte(3, 8'h10);
      @(negedge clk);
      chk("R10", "low byte second", ptr_value, ptr_m);

      // R8: card disabled across the 0x6000 boundary
      card_en = 1'b0;
      set_ptr(0, 16'h5FFF);
      data_acc(3, 1'b0);                  // served
      data_acc(9, 1'b0);                  // refused, bank stays 3
      data_acc(33, 1'b0);                 // refused
      chk("R11", "pointer past limit", ptr_value, 16'h6002);
      card_en = 1'b1;

      // R11: wrap
      set_ptr(0, 16'hFFFF);
      data_acc(2, 1'b0);
      chk("R11", "pointer wrap", ptr_value, 16'h0000);

      repeat (3) @(negedge clk);
      chk("R13", "scoreboard drained", exp_q.size(), 0);
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule